// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt

This block is a 24-bit interval counter on a small byte-wide register bus. It has three count-byte offsets and one control/status offset. Writing a byte offset stores one byte of the reload value. Reading the same offset returns that byte of the live counter.

The control byte sets up the timer:
- The counter advances on a tick from one of four sources: the system clock divided by 16, the system clock divided by 256, or rising or falling edges of an external input.
- The counter counts up or down.
- On terminal count, the counter can reload itself automatically.
- A control write can load the counter at once from the reload value.

Terminal count is the counter arriving at zero. On each terminal count, an output pin and an internal flag invert, and a pending flag is set. A level interrupt is driven while that flag is set and the interrupt is enabled. Software reads the status offset to see the flag and to acknowledge it.

Top module: `ivt_timer`

## Requirements
- R1: A write to offset 0, 1 or 2 stores the low, middle or high byte of the reload value. A read of offset 0, 1 or 2 returns the low, middle or high byte of the live counter. A control write (offset 3) with bit 6 set copies the reload value into the counter on that write's clock edge.
- R2: With control bit 0 clear, the tick comes from a prescaler. Control bit 4 clear selects one tick every 16 clocks, and bit 4 set selects one tick every 256 clocks. A control write that changes bits {4,0} restarts the prescaler, so the first counter step comes exactly 16 (or 256) clocks after that write.
- R3: With control bit 0 set, the external input passes through a two-flop synchronizer. Each rising edge (bit 4 clear) or each falling edge (bit 4 set) advances the counter by exactly one. The opposite edge has no effect.
- R4: Control bit 3 set makes each tick add one; bit 3 clear makes each tick subtract one. Without a tick or a load, the counter holds its value.
- R5: Terminal count is a tick that makes the next value zero, including the up-count wrap from 0xFFFFFF. Without auto-reload, the counter stays at zero and then keeps counting in the same direction (a down-count goes on to 0xFFFFFF).
- R6: With control bit 5 set, a terminal-count tick loads the reload value into the counter instead of zero.
- R7: A terminal count sets a pending flag, which reads back in status bit 0. A status read clears the flag, except when a terminal count happens in the same cycle; then the flag stays set.
- R8: `irq_o` is high exactly while the pending flag and control bit 7 are both set. Status bit 7 reads back control bit 7. Counting and the pending flag work the same whether or not the interrupt is enabled.
- R9: `tgl_out` follows control bit 2 as last written, and inverts on every terminal count.
- R10: After reset, the counter, reload value, control bits, pending flag, `irq_o` and `tgl_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per clock while high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Offset: 0..2 count bytes, 3 control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` |
| ext_clk_in | input | 1 | Asynchronous external count input |
| tgl_out | output | 1 | Output pin that inverts on terminal count |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives each terminal-count corner and states what a faulty design would do:
- **Up-count wrap from 0xFFFFFF.** A design that tests only a down-count reaching zero would never flag this terminal count.
- **Down-count past zero without auto-reload.** A design that stops at zero would stick there instead of going on to 0xFFFFFE.
- **Auto-reload of the all-ones value while counting up.** A design that loaded zero would leave a wrong count, and a miscounted toggle would leave the pin in the wrong state.
- **Status read landing on the same edge as a terminal count.** A design that gives the read priority would lose the interrupt.
- **Prescaler timing.** The bench times the first step after a source change at 16 and 256 clocks, so a prescaler that does not restart shows an early or late step.
- **Falling-edge mode.** The bench checks that a rising edge leaves the count untouched.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   // control byte bit positions
   localparam int CB_SRC_EXT = 0;   // 0: prescaler, 1: external input
   localparam int CB_FLAG    = 1;   // internal flag, inverts on terminal count
   localparam int CB_PIN     = 2;   // drives tgl_out
   localparam int CB_UP      = 3;   // 1: count up
   localparam int CB_SRC_ALT = 4;   // divide-256 / falling-edge select
   localparam int CB_AUTO    = 5;   // reload on terminal count
   localparam int CB_LOAD    = 6;   // write-only: load now
   localparam int CB_IRQEN   = 7;   // interrupt enable

   // tick source, encoded as {alt, ext}
   typedef enum logic [1:0] {
      SRC_DIV_LO   = 2'b00,
      SRC_EXT_RISE = 2'b01,
      SRC_DIV_HI   = 2'b10,
      SRC_EXT_FALL = 2'b11
   } src_e;

   function automatic src_e src_of(input logic [7:0] c);
      return src_e'({c[CB_SRC_ALT], c[CB_SRC_EXT]});
   endfunction

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen
   import ivt_pkg::*;
#(
   parameter int DIV_LO_LOG2 = 4,
   parameter int DIV_HI_LOG2 = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  src_e src,
   input  logic ext_in,
   output logic tick
);

   if (DIV_LO_LOG2 < 1 || DIV_HI_LOG2 <= DIV_LO_LOG2) begin : g_bad_div
      $error("ivt_tick_gen: need 1 <= DIV_LO_LOG2 < DIV_HI_LOG2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ivt_tick_gen: SYNC_STAGES must be at least 2");
   end

   // prescaler
   logic [DIV_HI_LOG2-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   logic div_lo_hit, div_hi_hit;
   assign div_lo_hit = &pre_q[DIV_LO_LOG2-1:0];
   assign div_hi_hit = &pre_q;

   // synchronizer and edge detector
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   logic ext_rise, ext_fall;
   assign ext_rise =  sync_q[SYNC_STAGES-1] & ~last_q;
   assign ext_fall = ~sync_q[SYNC_STAGES-1] &  last_q;

   always_comb begin
      unique case (src)
         SRC_DIV_LO:   tick = div_lo_hit;
         SRC_DIV_HI:   tick = div_hi_hit;
         SRC_EXT_RISE: tick = ext_rise;
         SRC_EXT_FALL: tick = ext_fall;
         default:      tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         up,
   input  logic         auto_rl,
   input  logic         load,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] cnt,
   output logic         tc
);

   logic [W-1:0] step;

   assign step = up ? cnt + 1'b1 : cnt - 1'b1;
   assign tc   = tick & ~load & (step == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= reload_val;
      else if (tc && auto_rl)  cnt <= reload_val;
      else if (tick)           cnt <= step;
   end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int COUNT_W     = 24,
   parameter int DIV_LO_LOG2 = 4,
   parameter int DIV_HI_LOG2 = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NBYTES     = COUNT_W / 8,
   localparam int ADDR_W     = $clog2(NBYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              ext_clk_in,
   output logic              tgl_out,
   output logic              irq_o
);

   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NBYTES);

   if (COUNT_W < 8 || (COUNT_W % 8) != 0) begin : g_bad_width
      $error("ivt_timer: COUNT_W must be a positive multiple of 8");
   end

   // bus decode
   logic ctrl_wr, stat_rd;
   assign ctrl_wr = bus_sel &  bus_we & (bus_addr == STAT_ADDR);
   assign stat_rd = bus_sel & ~bus_we & (bus_addr == STAT_ADDR);

   // reload value, written bytewise
   logic [COUNT_W-1:0] reload_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reload_q <= '0;
      else if (bus_sel && bus_we) begin
         for (int b = 0; b < NBYTES; b++)
            if (bus_addr == ADDR_W'(b)) reload_q[b*8 +: 8] <= bus_wdata;
      end
   end

   // control byte and pending flag
   logic [7:0] ctrl_q;
   logic       pend_q;
   logic       tc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_wr) begin
         ctrl_q          <= bus_wdata;
         ctrl_q[CB_LOAD] <= 1'b0;
      end else if (tc) begin
         ctrl_q[CB_PIN]  <= ~ctrl_q[CB_PIN];
         ctrl_q[CB_FLAG] <= ~ctrl_q[CB_FLAG];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (tc)      pend_q <= 1'b1;
      else if (stat_rd) pend_q <= 1'b0;
   end

   // the internal flag has no load by design
   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl_q[CB_FLAG], ctrl_q[CB_LOAD]};

   // tick source
   logic tick, restart, ld;
   assign restart = ctrl_wr && (src_of(bus_wdata) != src_of(ctrl_q));
   assign ld      = ctrl_wr & bus_wdata[CB_LOAD];

   ivt_tick_gen #(
      .DIV_LO_LOG2 (DIV_LO_LOG2),
      .DIV_HI_LOG2 (DIV_HI_LOG2),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .src     (src_of(ctrl_q)),
      .ext_in  (ext_clk_in),
      .tick    (tick)
   );

   // counter
   logic [COUNT_W-1:0] cnt;

   ivt_count #(.W(COUNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .up         (ctrl_q[CB_UP]),
      .auto_rl    (ctrl_q[CB_AUTO]),
      .load       (ld),
      .reload_val (reload_q),
      .cnt        (cnt),
      .tc         (tc)
   );

   // read lanes
   logic [7:0] cnt_byte [NBYTES];

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign cnt_byte[b] = cnt[b*8 +: 8];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == STAT_ADDR)
         bus_rdata = {ctrl_q[CB_IRQEN], 6'b0, pend_q};
      else
         for (int b = 0; b < NBYTES; b++)
            if (bus_addr == ADDR_W'(b)) bus_rdata = cnt_byte[b];
   end

   assign irq_o   = pend_q & ctrl_q[CB_IRQEN];
   assign tgl_out = ctrl_q[CB_PIN];

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
   parameter int COUNT_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               tc,
   input logic               ld,
   input logic               ctrl_wr,
   input logic               stat_rd,
   input logic               pend_q,
   input logic               irq_o,
   input logic               tgl_out,
   input logic               up,
   input logic               auto_rl,
   input logic               irq_en,
   input logic [COUNT_W-1:0] cnt,
   input logic [COUNT_W-1:0] reload_q
);

   a_r7_tc_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> pend_q);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tc) |=> !pend_q);

   a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_en);

   a_r9_pin_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !ctrl_wr) |=> (tgl_out != $past(tgl_out)));

   a_r9_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tc && !ctrl_wr) |=> $stable(tgl_out));

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(cnt));

   a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && !up && !tc) |=> (cnt == $past(cnt) - 1'b1));

   a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && up && !tc) |=> (cnt == $past(cnt) + 1'b1));

   a_r5_zero_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !auto_rl) |=> (cnt == '0));

   a_r6_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && auto_rl) |=> (cnt == $past(reload_q)));

   a_r1_load_now: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt == $past(reload_q)));

endmodule

bind ivt_timer ivt_timer_chk #(.COUNT_W(COUNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .tc       (tc),
   .ld       (ld),
   .ctrl_wr  (ctrl_wr),
   .stat_rd  (stat_rd),
   .pend_q   (pend_q),
   .irq_o    (irq_o),
   .tgl_out  (tgl_out),
   .up       (ctrl_q[3]),
   .auto_rl  (ctrl_q[5]),
   .irq_en   (ctrl_q[7]),
   .cnt      (cnt),
   .reload_q (reload_q)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ext_clk_in = 1'b0;
   logic       tgl_out;
   logic       irq_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   ivt_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ext_clk_in (ext_clk_in),
      .tgl_out    (tgl_out),
      .irq_o      (irq_o)
   );

   // vector: reload, edges, up, auto, expected count, pending, pin
   typedef struct packed {
      logic [23:0] reload;
      logic [7:0]  edges;
      logic        up;
      logic        auto_rl;
      logic [23:0] exp_cnt;
      logic        exp_pend;
      logic        exp_pin;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      {24'd5,        8'd3, 1'b0, 1'b0, 24'd2,        1'b0, 1'b0},
      {24'd5,        8'd5, 1'b0, 1'b0, 24'd0,        1'b1, 1'b1},
      {24'd3,        8'd4, 1'b0, 1'b1, 24'd2,        1'b1, 1'b1},
      {24'hFFFFFE,   8'd3, 1'b1, 1'b0, 24'd1,        1'b1, 1'b1},
      {24'd2,        8'd4, 1'b0, 1'b0, 24'hFFFFFE,   1'b1, 1'b1},
      {24'hFFFFFF,   8'd2, 1'b1, 1'b1, 24'hFFFFFF,   1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic rd_count(output logic [23:0] v);
      logic [7:0] b0, b1, b2;
      bus_rd(2'd0, b0);
      bus_rd(2'd1, b1);
      bus_rd(2'd2, b2);
      v = {b2, b1, b0};
   endtask

   task automatic set_reload(input logic [23:0] v);
      bus_wr(2'd0, v[7:0]);
      bus_wr(2'd1, v[15:8]);
      bus_wr(2'd2, v[23:16]);
   endtask

   task automatic ext_pulse();
      @(negedge clk) ext_clk_in = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk) ext_clk_in = 1'b0;
      repeat (5) @(posedge clk);
   endtask

   // clocks from the control write until the low count byte changes
   task automatic time_step(input logic [7:0] base, output int k);
      k = 0;
      bus_addr = 2'd0;
      for (int i = 0; i < 1000; i++) begin
         @(posedge clk);
         #1 k++;
         if (bus_rdata != base) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0]  d;
      logic [23:0] v;
      int          k;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10 reset state
      for (int a = 0; a < 4; a++) begin
         bus_rd(2'(a), d);
         chk("R10 reset register", {24'd0, d}, 32'd0);
      end
      chk("R10 reset irq_o", {31'd0, irq_o}, 32'd0);
      chk("R10 reset tgl_out", {31'd0, tgl_out}, 32'd0);

      // vector table: external rising edges, irq enabled
      for (int n = 0; n < NVEC; n++) begin
         set_reload(VEC[n].reload);
         bus_wr(2'd3, 8'hC1 | ({7'd0, VEC[n].up} << 3) | ({7'd0, VEC[n].auto_rl} << 5));
         bus_rd(2'd3, d);
         rd_count(v);
         chk("R1 immediate reload", {8'd0, v}, {8'd0, VEC[n].reload});
         for (int e = 0; e < int'(VEC[n].edges); e++) ext_pulse();
         repeat (4) @(posedge clk);
         #1;
         chk("R8 irq level", {31'd0, irq_o}, {31'd0, VEC[n].exp_pend});
         chk("R9 pin after terminal counts", {31'd0, tgl_out}, {31'd0, VEC[n].exp_pin});
         rd_count(v);
         chk("R3 R4 R5 R6 count after edges", {8'd0, v}, {8'd0, VEC[n].exp_cnt});
         bus_rd(2'd3, d);
         chk("R7 status pending", {24'd0, d}, {24'd0, 7'h40, VEC[n].exp_pend} | 32'h80);
      end

      // R7 status read clears
      bus_rd(2'd3, d);
      chk("R7 pending cleared by read", {24'd0, d}, 32'h80);
      chk("R8 irq drops after read", {31'd0, irq_o}, 32'd0);

      // R3 falling-edge mode
      set_reload(24'd10);
      bus_wr(2'd3, 8'h51);
      @(negedge clk) ext_clk_in = 1'b1;
      repeat (6) @(posedge clk);
      rd_count(v);
      chk("R3 rising edge ignored in falling mode", {8'd0, v}, 32'd10);
      @(negedge clk) ext_clk_in = 1'b0;
      repeat (6) @(posedge clk);
      rd_count(v);
      chk("R3 falling edge counted", {8'd0, v}, 32'd9);

      // R8 counting with interrupt disabled
      set_reload(24'd1);
      bus_wr(2'd3, 8'h41);
      bus_rd(2'd3, d);
      ext_pulse();
      #1;
      chk("R8 no irq when disabled", {31'd0, irq_o}, 32'd0);
      bus_rd(2'd3, d);
      chk("R8 pending set while disabled", {24'd0, d}, 32'h01);
      bus_rd(2'd3, d);
      chk("R7 second read sees clear", {24'd0, d}, 32'h00);

      // R7 status read on the same edge as a terminal count
      bus_wr(2'd3, 8'hC1);
      bus_rd(2'd3, d);
      @(negedge clk) ext_clk_in = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 2'd3;
      @(posedge clk);
      #1 bus_sel = 1'b0;
      chk("R7 collision keeps irq", {31'd0, irq_o}, 32'd1);
      bus_rd(2'd3, d);
      chk("R7 collision keeps pending", {24'd0, d}, 32'h81);
      @(negedge clk) ext_clk_in = 1'b0;
      repeat (5) @(posedge clk);

      // R9 pin follows written bit 2
      bus_wr(2'd3, 8'h05);
      #1;
      chk("R9 pin written high", {31'd0, tgl_out}, 32'd1);

      // R2 prescaler divide by 16
      set_reload(24'd100);
      bus_wr(2'd3, 8'h01);
      bus_wr(2'd3, 8'h40);
      time_step(8'd100, k);
      chk("R2 first divide-16 step", k, 32'd16);
      time_step(8'd99, k);
      chk("R2 second divide-16 step", k, 32'd16);

      // R2 prescaler divide by 256
      bus_wr(2'd3, 8'h01);
      bus_wr(2'd3, 8'h50);
      time_step(8'd100, k);
      chk("R2 first divide-256 step", k, 32'd256);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule